// File: doc/BRIEF.md
# Serial NOR flash program and erase sequencer

This block sits on the host side of a serial NOR flash and drives it as an SPI master in mode 0. A user asks for one of three things through a valid/ready request port: erase one sector, erase the whole array, or program a run of bytes starting at some address. The program bytes arrive on a separate byte stream with its own valid/ready pair. The block turns each request into the full command sequence the flash needs. That sequence is a write-enable frame, then the operation frame, then status-read frames repeated until the busy bit clears.

A program request of any length is cut into chunks so that no frame crosses a 256-byte page. The first chunk runs from the start address to the end of its page. Each later chunk holds 256 bytes, or whatever remains if that is less. Every chunk gets its own write-enable and its own polling. If the flash reports busy on a set number of consecutive polls, the request is abandoned and an error flag is raised. The SPI clock is the system clock divided by a parameter.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, busy, done, err and wr_ready are low, and req_ready is high.
- R2: Every operation frame is preceded by a frame holding only the write-enable opcode 0x06. Chip select goes high between the two frames.
- R3: The sector-erase frame is opcode 0xD8 followed by the 24-bit address, most significant byte first. The whole-array erase frame is the single byte 0xC7. Request code req_op=00 selects sector erase, 01 selects whole-array erase, and 1x selects program.
- R4: A program frame is opcode 0x02, then three address bytes, then at most 256 data bytes, all in the page of the header address. The first chunk ends at its page end, and each later chunk is min(256, remaining) long.
- R5: After each operation frame, the block issues read-status frames. Each is opcode 0x05 plus one read byte, with chip select high between them. Bit 0 of the read byte is the write-in-progress flag. No other command follows until a poll returns that bit as 0.
- R6: The serial clock is low whenever chip select is high. Data out changes only while the clock is low, bytes go most significant bit first, and data in is taken on the rising clock edge.
- R7: busy is high from the cycle after a request is accepted until the request ends. req_ready is high only while idle. A successful request gives exactly one single-cycle done pulse.
- R8: If POLL_LIMIT consecutive polls all read busy, the block stops after that poll, sets err, gives no done pulse and goes idle. err is cleared when the next request is accepted.
- R9: A program request with length 0 produces no frames and gives a done pulse with busy staying low.
- R10: Program bytes are taken from the stream in order, one per handshake. wr_ready is high only when a data byte is due inside an open program frame. While the stream is stalled, chip select stays low and the clock stays parked low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and accepting a request |
| req_op | input | 2 | 00 sector erase, 01 whole-array erase, 1x program |
| req_addr | input | 24 | Start address (sector address for erase) |
| req_len | input | LEN_W | Number of bytes to program |
| wr_valid | input | 1 | Program byte offered |
| wr_ready | output | 1 | Block takes the program byte |
| wr_data | input | 8 | Program byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Poll timeout on the last request |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Data to the flash |
| spi_miso | input | 1 | Data from the flash |

## Verification
The bench attaches a behavioural flash that logs every frame and reports busy for a chosen number of polls. It targets a program run that starts 16 bytes before a page end and spans three pages. A design that split only by length would push bytes past the page end, and the flash would wrap them onto the start of the same page. It also checks that a fresh write-enable starts every chunk and that a status poll is never skipped. Missing either would show up as an operation sent to a flash that still has its write latch clear or is still busy.

Two further cases are checked. A stuck-busy flash must end after exactly the poll limit, with err set and no done pulse; an off-by-one counter would show one poll too many or too few. A zero-length program must complete with no frames. The stream is also throttled mid-frame to catch clock edges produced while no byte was loaded.

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int CLK_DIV = 2,
  parameter int POLL_LIMIT = 4096,
  parameter int LEN_W = 16,
  parameter logic [7:0] OPC_WEN  = 8'h06,
  parameter logic [7:0] OPC_PROG = 8'h02,
  parameter logic [7:0] OPC_SECT = 8'hD8,
  parameter logic [7:0] OPC_CHIP = 8'hC7,
  parameter logic [7:0] OPC_STAT = 8'h05
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int DIV_W  = $clog2(CLK_DIV) + 1;
  localparam int POLL_W = $clog2(POLL_LIMIT) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_GAP} st_t;
  typedef enum logic [1:0] {FR_WEN, FR_OP, FR_POLL} fr_t;

  st_t st;
  fr_t fr;
  logic [1:0]       op_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] rem_q;
  logic [8:0]       chunk_q, idx, flen;
  logic [POLL_W-1:0] polls;
  logic [7:0]       tx, rx, opcode, next_byte;
  logic [2:0]       bitn;
  logic [DIV_W-1:0] div;
  logic             gap_half;

  function automatic logic [8:0] chunk_of(input logic [23:0] a, input logic [LEN_W-1:0] r);
    int unsigned room, rr;
    room = 32'd256 - 32'(a[7:0]);
    rr   = 32'(r);
    return (rr < room) ? 9'(rr) : 9'(room);
  endfunction

  wire tick      = (div == DIV_W'(CLK_DIV - 1));
  wire is_prog   = op_q[1];
  wire data_slot = (fr == FR_OP) && is_prog && (idx >= 9'd4);
  wire frame_end = (idx == flen);

  assign req_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign wr_ready  = (st == ST_LOAD) && data_slot && !frame_end;
  assign spi_mosi  = tx[7];

  always_comb begin
    case (fr)
      FR_WEN:  flen = 9'd1;
      FR_POLL: flen = 9'd2;
      default: flen = is_prog ? 9'd4 + chunk_q : (op_q[0] ? 9'd1 : 9'd4);
    endcase
    case (fr)
      FR_WEN:  opcode = OPC_WEN;
      FR_POLL: opcode = OPC_STAT;
      default: opcode = is_prog ? OPC_PROG : (op_q[0] ? OPC_CHIP : OPC_SECT);
    endcase
    case (idx)
      9'd0:    next_byte = opcode;
      9'd1:    next_byte = (fr == FR_POLL) ? 8'h00 : addr_q[23:16];
      9'd2:    next_byte = addr_q[15:8];
      9'd3:    next_byte = addr_q[7:0];
      default: next_byte = wr_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  fr <= FR_WEN;  op_q <= '0;  addr_q <= '0;  rem_q <= '0;
      chunk_q <= '0;  idx <= '0;  polls <= '0;  tx <= '0;  rx <= '0;  bitn <= '0;
      div <= '0;  gap_half <= 1'b0;  spi_sck <= 1'b0;  spi_cs_n <= 1'b1;
      done <= 1'b0;  err <= 1'b0;
    end else begin
      done <= 1'b0;
      div  <= (st == ST_IDLE || st == ST_LOAD || tick) ? '0 : div + DIV_W'(1);
      case (st)
        ST_IDLE: if (req_valid) begin
          op_q    <= req_op;
          addr_q  <= req_addr;
          rem_q   <= req_len;
          chunk_q <= chunk_of(req_addr, req_len);
          err     <= 1'b0;
          fr      <= FR_WEN;
          idx     <= '0;
          if (req_op[1] && req_len == '0) done <= 1'b1;
          else st <= ST_LOAD;
        end
        ST_LOAD: if (frame_end) begin
          spi_cs_n <= 1'b1;
          gap_half <= 1'b0;
          st       <= ST_GAP;
        end else if (!data_slot || wr_valid) begin
          tx       <= next_byte;
          spi_cs_n <= 1'b0;
          bitn     <= '0;
          st       <= ST_SHIFT;
          if (data_slot) begin
            addr_q <= addr_q + 24'd1;
            rem_q  <= rem_q - LEN_W'(1);
          end
        end
        ST_SHIFT: if (tick) begin
          if (!spi_sck) begin
            spi_sck <= 1'b1;
            rx      <= {rx[6:0], spi_miso};
          end else begin
            spi_sck <= 1'b0;
            tx      <= {tx[6:0], 1'b0};
            bitn    <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              idx <= idx + 9'd1;
              st  <= ST_LOAD;
            end
          end
        end
        ST_GAP: if (tick) begin
          gap_half <= ~gap_half;
          if (gap_half) begin
            idx <= '0;
            st  <= ST_LOAD;
            case (fr)
              FR_WEN: fr <= FR_OP;
              FR_OP: begin
                fr    <= FR_POLL;
                polls <= '0;
              end
              default: begin
                if (rx[0]) begin
                  if (polls == POLL_W'(POLL_LIMIT - 1)) begin
                    err <= 1'b1;
                    st  <= ST_IDLE;
                  end else begin
                    polls <= polls + POLL_W'(1);
                  end
                end else if (is_prog && rem_q != '0) begin
                  fr      <= FR_WEN;
                  chunk_q <= chunk_of(addr_q, rem_q);
                end else begin
                  done <= 1'b1;
                  st   <= ST_IDLE;
                end
              end
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_sck_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  assert_done_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !err));
  assert_data_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !spi_cs_n);
  assert_page_stay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && idx > 9'd4) |-> (addr_q[7:0] != 8'd0));
  assert_chunk_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (chunk_q <= 9'd256));
  assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    polls < POLL_W'(POLL_LIMIT));
  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy);
endmodule

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int POLLS_MAX = 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, wr_valid = 1, spi_miso = 0;
  logic [1:0] req_op = 0;
  logic [23:0] req_addr = 0;
  logic [15:0] req_len = 0;
  logic [7:0] wr_data;
  logic req_ready, wr_ready, busy, done, err, spi_sck, spi_cs_n, spi_mosi;

  flash_prog_seq #(.CLK_DIV(2), .POLL_LIMIT(POLLS_MAX), .LEN_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  // program data stream
  int feed_idx = 0, prog_base = 0;
  bit stall = 0;
  assign wr_data = pat(feed_idx);
  always @(posedge clk) if (wr_valid && wr_ready) feed_idx <= feed_idx + 1;
  always @(negedge clk) wr_valid <= stall ? ~wr_valid : 1'b1;

  // behavioural flash
  bit wel = 0, wip = 0, open_f = 0;
  int busy_polls = 0, polls_left = 0, bits = 0, dcount = 0;
  logic [7:0] sh = 0, cmd = 0, stat_l = 0;
  logic [23:0] hdr = 0;
  int seq_bad = 0, page_bad = 0, data_bad = 0, data_total = 0, npolls = 0, nfr = 0;
  int fcmd[64], flen[64], fdat[64];
  logic [23:0] fhdr[64];

  always @(negedge spi_cs_n) begin
    open_f = 1; bits = 0; dcount = 0; cmd = 0; hdr = 0;
    stat_l = {6'b0, wel, wip};
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    bits++;
    if (bits % 8 == 0) begin
      if (bits == 8) cmd = sh;
      else if (bits <= 32) hdr = {hdr[15:0], sh};
      else if (cmd == 8'h02) begin
        if (int'(hdr[7:0]) + dcount > 255) page_bad++;
        if (sh !== pat(int'(hdr) + dcount - prog_base)) data_bad++;
        dcount++;
        data_total++;
      end
    end
  end

  always @(negedge spi_sck) if (!spi_cs_n && cmd == 8'h05 && bits >= 8)
    spi_miso = stat_l[3'(7 - ((bits - 8) % 8))];

  always @(posedge spi_cs_n) if (open_f) begin
    open_f = 0;
    if (nfr < 64) begin
      fcmd[nfr] = int'(cmd); flen[nfr] = bits / 8; fhdr[nfr] = hdr; fdat[nfr] = dcount;
    end
    nfr++;
    if (bits % 8 != 0) seq_bad++;
    if (cmd != 8'h05 && wip) seq_bad++;
    case (cmd)
      8'h06: wel = 1;
      8'h02, 8'hD8, 8'hC7: begin
        if (!wel) seq_bad++;
        wel = 0;
        polls_left = busy_polls;
        wip = (busy_polls > 0);
      end
      8'h05: begin
        npolls++;
        if (polls_left > 0) begin
          polls_left--;
          if (polls_left == 0) wip = 0;
        end
      end
      default: seq_bad++;
    endcase
  end

  // pin-level monitor
  logic prev_sck = 0, prev_mosi = 0;
  int mode_bad = 0, done_cnt = 0, hs_bad = 0;
  always @(negedge clk) if (rst_n) begin
    if (prev_sck && spi_sck && spi_mosi !== prev_mosi) mode_bad++;
    if (spi_cs_n && spi_sck) mode_bad++;
    if (done) done_cnt++;
    if (busy && req_ready) hs_bad++;
    if (!spi_cs_n && !busy) hs_bad++;
    if (wr_ready && spi_cs_n) hs_bad++;
    prev_sck = spi_sck;
    prev_mosi = spi_mosi;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [23:0] a, input int len, input int bp);
    busy_polls = bp; nfr = 0; npolls = 0; seq_bad = 0; page_bad = 0; data_bad = 0;
    data_total = 0; mode_bad = 0; hs_bad = 0; done_cnt = 0; prog_base = int'(a); feed_idx = 0;
    @(negedge clk);
    req_op = op; req_addr = a; req_len = 16'(len); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic frame_is(input int i, input int c, input int l, input string tag);
    chk(fcmd[i] == c, tag, fcmd[i], c);
    chk(flen[i] == l, tag, flen[i], l);
  endtask

  task automatic common_ok(input string tag);
    chk(seq_bad == 0, {tag, " R2 R5 ordering"}, seq_bad, 0);
    chk(mode_bad == 0, {tag, " R6 spi timing"}, mode_bad, 0);
    chk(hs_bad == 0, {tag, " R7 R10 handshake"}, hs_bad, 0);
  endtask

  task automatic t_reset;
    chk(spi_cs_n === 1'b1, "R1 cs high", int'(spi_cs_n), 1);
    chk(spi_sck === 1'b0, "R1 sck low", int'(spi_sck), 0);
    chk({busy, done, err, wr_ready} === 4'b0, "R1 status low", int'({busy, done, err, wr_ready}), 0);
    chk(req_ready === 1'b1, "R1 ready", int'(req_ready), 1);
  endtask

  task automatic t_sector;
    issue(2'b00, 24'h012345, 0, 2);
    chk(nfr == 5, "R5 sector frame count", nfr, 5);
    frame_is(0, 8'h06, 1, "R2 wren first");
    frame_is(1, 8'hD8, 4, "R3 sector frame");
    chk(fhdr[1] == 24'h012345, "R3 sector address", int'(fhdr[1]), 24'h012345);
    frame_is(2, 8'h05, 2, "R5 status frame");
    chk(npolls == 3, "R5 polls until clear", npolls, 3);
    chk(done_cnt == 1, "R7 one done", done_cnt, 1);
    common_ok("sector");
  endtask

  task automatic t_chip;
    issue(2'b01, 24'h0, 0, 0);
    chk(nfr == 3, "R3 chip frame count", nfr, 3);
    frame_is(1, 8'hC7, 1, "R3 chip frame");
    chk(npolls == 1, "R5 single poll", npolls, 1);
    chk(done_cnt == 1, "R7 chip done", done_cnt, 1);
    common_ok("chip");
  endtask

  task automatic t_prog_small;
    issue(2'b10, 24'h000010, 5, 1);
    chk(nfr == 4, "R4 small frame count", nfr, 4);
    frame_is(1, 8'h02, 9, "R4 small program frame");
    chk(fhdr[1] == 24'h000010, "R4 small address", int'(fhdr[1]), 16);
    chk(data_bad == 0 && data_total == 5, "R10 small data", data_total, 5);
    chk(done_cnt == 1, "R7 small done", done_cnt, 1);
    common_ok("small");
  endtask

  task automatic t_prog_split;
    stall = 1;
    issue(2'b10, 24'h0000F0, 300, 1);
    stall = 0;
    chk(nfr == 12, "R4 split frame count", nfr, 12);
    chk(fdat[1] == 16 && fhdr[1] == 24'h0000F0, "R4 first chunk to page end", fdat[1], 16);
    frame_is(4, 8'h06, 1, "R2 wren per chunk");
    chk(fdat[5] == 256 && fhdr[5] == 24'h000100, "R4 full middle chunk", fdat[5], 256);
    chk(fdat[9] == 28 && fhdr[9] == 24'h000200, "R4 tail chunk", fdat[9], 28);
    chk(page_bad == 0, "R4 page crossing", page_bad, 0);
    chk(data_bad == 0 && data_total == 300 && feed_idx == 300, "R10 split data order", data_total, 300);
    chk(done_cnt == 1, "R7 split done", done_cnt, 1);
    common_ok("split");
  endtask

  task automatic t_prog_aligned;
    issue(2'b11, 24'h000300, 256, 0);
    chk(nfr == 3, "R4 aligned frame count", nfr, 3);
    frame_is(1, 8'h02, 260, "R4 full page frame");
    chk(data_bad == 0 && page_bad == 0, "R4 aligned data", data_bad + page_bad, 0);
    common_ok("aligned");
  endtask

  task automatic t_timeout;
    issue(2'b00, 24'h001000, 0, 100000);
    chk(npolls == POLLS_MAX, "R8 poll limit", npolls, POLLS_MAX);
    chk(err === 1'b1, "R8 err set", int'(err), 1);
    chk(done_cnt == 0, "R8 no done", done_cnt, 0);
    chk(busy === 1'b0, "R8 idle after timeout", int'(busy), 0);
    wip = 0; polls_left = 0;
    issue(2'b01, 24'h0, 0, 0);
    chk(err === 1'b0, "R8 err cleared", int'(err), 0);
    chk(done_cnt == 1, "R8 next request done", done_cnt, 1);
  endtask

  task automatic t_zero;
    issue(2'b10, 24'h000050, 0, 0);
    chk(nfr == 0, "R9 no frames", nfr, 0);
    chk(done_cnt == 1, "R9 done pulse", done_cnt, 1);
    chk(hs_bad == 0, "R9 busy low", hs_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_sector;
    t_chip;
    t_prog_small;
    t_prog_split;
    t_prog_aligned;
    t_timeout;
    t_zero;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule